// File: doc/BRIEF.md
# SDRAM Full-Page Write Burst Unit

This block is the device-side write path of one bank of a synchronous DRAM with the burst length fixed at full page. On every rising clock edge it takes one decoded command together with a bank select, a column address, an auto-precharge request bit, a per-cycle data mask and a data word. An activate opens the row. A write starts a burst at the given column, and the word on the write cycle is the first beat. Every following cycle without a command for this bank is another beat at the next column. The column counter wraps from the last column back to column 0, so a burst never ends by itself.

A burst ends only on a burst stop or a precharge. The data word on that cycle is thrown away. A precharge also closes the row, and from then on all input data is ignored until the next activate. The open row is modelled by a small register array. A combinational peek port lets the surrounding logic read the array.

Top module: `sdram_wburst`

## Requirements
- R1: After synchronous reset (active-high `rst`), the row is closed, no burst is active, `beat_col` is 0, both error flags are low and every array word reads 0.
- R2: During a burst, each continuing beat advances `beat_col` by one, and from column COLS-1 it wraps to column 0. The burst continues across the wrap until a command ends it.
- R3: `cmd` encoding: 0 no-op, 1 activate, 2 write, 3 burst stop, 4 precharge; the codes 5 to 7 act as no-op. A write to an open row stores `din` at `col` in the same cycle and sets `beat_col` to the next column. Each later no-op cycle stores `din` at `beat_col` and advances the counter.
- R4: On a burst stop, `din` is not written and the burst ends. `beat_col` holds, and later data is not written.
- R5: On a precharge, `din` is not written, the burst ends and the row closes.
- R6: While the row is closed, no input data reaches the array, whatever the mask.
- R7: A write with `auto_pre` high to an open row raises `err_auto_pre` for one cycle. No precharge follows, and the burst runs as a normal full-page burst.
- R8: A write to a closed row raises `err_no_row` for one cycle. It writes nothing and starts no burst.
- R9: A high `dqm` blocks the write of that beat only. The column counter still advances.
- R10: A write issued during an active burst restarts the burst at its own column.
- R11: Commands whose `bank` differs from BANK_ID act as a no-op for this unit, so a running burst continues through them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 3 | Decoded command code |
| bank | input | BANK_W | Bank select of the command |
| col | input | COL_W | Start column of a write |
| auto_pre | input | 1 | Auto-precharge request with a write |
| dqm | input | 1 | Data mask for this cycle |
| din | input | DATA_W | Input data word |
| peek_col | input | COL_W | Array read column |
| peek_data | output | DATA_W | Array word at `peek_col` (combinational) |
| row_open | output | 1 | Row is activated |
| burst_active | output | 1 | Write burst in progress |
| beat_col | output | COL_W | Column of the next continuing beat |
| err_no_row | output | 1 | One-cycle flag: write to a closed row |
| err_auto_pre | output | 1 | One-cycle flag: auto precharge requested |

## Verification
The first burst starts near the end of the row and runs ten beats. It includes one masked beat and one undefined command code, then ends with a burst stop that carries data. This shows that the wrap writes columns 0 and up, that a mask skips a column without stalling the counter, and that the stop data is dropped. The second burst asks for auto precharge and passes through a precharge addressed to the other bank. It is then restarted by a new write and ends with a precharge that carries unmasked data. This separates the bank filter, the restart and the precharge discard from each other. Writes before any activate and after the precharge check the closed-row error and the closed-row silence. A reference model is compared on every clock, and the whole array is swept at each checkpoint.

// File: rtl/sdram_wb_pkg.sv
`timescale 1ns/1ps
package sdram_wb_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_WR  = 3'd2,
    CMD_BST = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  // next column of a full-page burst, wrapping at the row end
  function automatic int unsigned wrap_next(int unsigned c, int unsigned ncols);
    return (c + 1 >= ncols) ? 0 : c + 1;
  endfunction
endpackage

// File: rtl/wb_cmd_decode.sv
`timescale 1ns/1ps
module wb_cmd_decode #(
  parameter int BANK_W  = 1,
  parameter int BANK_ID = 0
) (
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  output logic              hit_act,
  output logic              hit_wr,
  output logic              hit_bst,
  output logic              hit_pre,
  output logic              idle
);
  import sdram_wb_pkg::*;

  logic mine;
  assign mine = (bank == BANK_W'(BANK_ID));

  always_comb begin
    hit_act = 1'b0;
    hit_wr  = 1'b0;
    hit_bst = 1'b0;
    hit_pre = 1'b0;
    if (mine) begin
      unique case (cmd)
        CMD_ACT: hit_act = 1'b1;
        CMD_WR:  hit_wr  = 1'b1;
        CMD_BST: hit_bst = 1'b1;
        CMD_PRE: hit_pre = 1'b1;
        default: ;
      endcase
    end
    idle = !(hit_act || hit_wr || hit_bst || hit_pre);
  end
endmodule

// File: rtl/wb_col_counter.sv
`timescale 1ns/1ps
module wb_col_counter #(
  parameter int COLS  = 16,
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             advance,
  input  logic             halt,
  output logic             active,
  output logic [COL_W-1:0] col_q
);
  import sdram_wb_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      col_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      col_q  <= COL_W'(wrap_next(int'(start_col), COLS));
    end else if (halt) begin
      active <= 1'b0;
    end else if (advance && active) begin
      col_q  <= COL_W'(wrap_next(int'(col_q), COLS));
    end
  end
endmodule

// File: rtl/wb_row_array.sv
`timescale 1ns/1ps
module wb_row_array #(
  parameter int COLS   = 16,
  parameter int COL_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [COL_W-1:0]  wcol,
  input  logic [DATA_W-1:0] wdata,
  input  logic [COL_W-1:0]  rcol,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [COLS];

  for (genvar g = 0; g < COLS; g++) begin : g_cell
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (we && (wcol == COL_W'(g))) q <= wdata;
    end
    assign cells[g] = q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < COLS; i++)
      if (rcol == COL_W'(i)) rdata = cells[i];
  end
endmodule

// File: rtl/sdram_wburst.sv
`timescale 1ns/1ps
module sdram_wburst #(
  parameter int COLS    = 16,
  parameter int DATA_W  = 16,
  parameter int BANK_W  = 1,
  parameter int BANK_ID = 0,
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  input  logic              auto_pre,
  input  logic              dqm,
  input  logic [DATA_W-1:0] din,
  input  logic [COL_W-1:0]  peek_col,
  output logic [DATA_W-1:0] peek_data,
  output logic              row_open,
  output logic              burst_active,
  output logic [COL_W-1:0]  beat_col,
  output logic              err_no_row,
  output logic              err_auto_pre
);
  // internal events, named for the checker
  logic             hit_act, hit_wr, hit_bst, hit_pre, idle;
  logic             wr_start;
  logic             cont_beat;
  logic             wr_fire;
  logic [COL_W-1:0] wr_col;
  logic             halt;

  wb_cmd_decode #(.BANK_W(BANK_W), .BANK_ID(BANK_ID)) u_dec (
    .cmd(cmd), .bank(bank),
    .hit_act(hit_act), .hit_wr(hit_wr), .hit_bst(hit_bst),
    .hit_pre(hit_pre), .idle(idle)
  );

  assign wr_start  = hit_wr && row_open;
  assign cont_beat = idle && row_open && burst_active;
  assign halt      = hit_bst || hit_pre || hit_act;
  assign wr_fire   = (wr_start || cont_beat) && !dqm;
  assign wr_col    = hit_wr ? col : beat_col;

  wb_col_counter #(.COLS(COLS), .COL_W(COL_W)) u_cnt (
    .clk(clk), .rst(rst),
    .start(wr_start), .start_col(col),
    .advance(cont_beat), .halt(halt),
    .active(burst_active), .col_q(beat_col)
  );

  wb_row_array #(.COLS(COLS), .COL_W(COL_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst(rst),
    .we(wr_fire), .wcol(wr_col), .wdata(din),
    .rcol(peek_col), .rdata(peek_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      row_open     <= 1'b0;
      err_no_row   <= 1'b0;
      err_auto_pre <= 1'b0;
    end else begin
      if (hit_act)      row_open <= 1'b1;
      else if (hit_pre) row_open <= 1'b0;
      err_no_row   <= hit_wr && !row_open;
      err_auto_pre <= wr_start && auto_pre;
    end
  end
endmodule

// File: rtl/sdram_wb_checker.sv
`timescale 1ns/1ps
module sdram_wb_checker #(
  parameter int COLS  = 16,
  parameter int COL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             hit_wr,
  input logic             hit_bst,
  input logic             hit_pre,
  input logic             auto_pre,
  input logic             dqm,
  input logic [COL_W-1:0] col,
  input logic             cont_beat,
  input logic             wr_fire,
  input logic             row_open,
  input logic             burst_active,
  input logic [COL_W-1:0] beat_col,
  input logic             err_no_row,
  input logic             err_auto_pre
);
  import sdram_wb_pkg::*;

  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    cont_beat |=> beat_col == COL_W'(wrap_next(int'($past(beat_col)), COLS)));

  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (cont_beat && beat_col == COL_W'(COLS - 1)) |=> (beat_col == '0 && burst_active));

  a_r4_stop_drops: assert property (@(posedge clk) disable iff (rst)
    hit_bst |-> !wr_fire);

  a_r4_stop_ends: assert property (@(posedge clk) disable iff (rst)
    hit_bst |=> !burst_active);

  a_r5_pre_closes: assert property (@(posedge clk) disable iff (rst)
    hit_pre |=> (!row_open && !burst_active));

  a_r5_pre_drops: assert property (@(posedge clk) disable iff (rst)
    hit_pre |-> !wr_fire);

  a_r6_closed_silent: assert property (@(posedge clk) disable iff (rst)
    !row_open |-> !wr_fire);

  a_r7_no_auto_pre: assert property (@(posedge clk) disable iff (rst)
    (hit_wr && row_open && auto_pre) |=> (err_auto_pre && row_open && burst_active));

  a_r8_no_row: assert property (@(posedge clk) disable iff (rst)
    (hit_wr && !row_open) |=> (err_no_row && !burst_active));

  a_r9_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    dqm |-> !wr_fire);

  a_r10_restart: assert property (@(posedge clk) disable iff (rst)
    (hit_wr && row_open) |=> (burst_active &&
      beat_col == COL_W'(wrap_next(int'($past(col)), COLS))));
endmodule

bind sdram_wburst sdram_wb_checker #(.COLS(COLS), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst(rst), .hit_wr(hit_wr), .hit_bst(hit_bst), .hit_pre(hit_pre),
  .auto_pre(auto_pre), .dqm(dqm), .col(col), .cont_beat(cont_beat),
  .wr_fire(wr_fire), .row_open(row_open), .burst_active(burst_active),
  .beat_col(beat_col), .err_no_row(err_no_row), .err_auto_pre(err_auto_pre)
);

// File: tb/tb_sdram_wburst.sv
`timescale 1ns/1ps
module tb_sdram_wburst;
  localparam int NC = 16;
  localparam int CW = 4;
  localparam int DW = 16;
  localparam int C_NOP = 0, C_ACT = 1, C_WR = 2, C_BST = 3, C_PRE = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    cmd = '0;
  logic [0:0]    bank = '0;
  logic [CW-1:0] col = '0;
  logic          auto_pre = 1'b0;
  logic          dqm = 1'b0;
  logic [DW-1:0] din = '0;
  logic [CW-1:0] peek_col = '0;
  logic [DW-1:0] peek_data;
  logic          row_open, burst_active, err_no_row, err_auto_pre;
  logic [CW-1:0] beat_col;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int mref [NC];
  bit m_open, m_burst, m_enr, m_eap;
  int m_col;

  sdram_wburst #(.COLS(NC), .DATA_W(DW), .BANK_W(1), .BANK_ID(0)) dut (
    .clk(clk), .rst(rst), .cmd(cmd), .bank(bank), .col(col),
    .auto_pre(auto_pre), .dqm(dqm), .din(din), .peek_col(peek_col),
    .peek_data(peek_data), .row_open(row_open), .burst_active(burst_active),
    .beat_col(beat_col), .err_no_row(err_no_row), .err_auto_pre(err_auto_pre)
  );

  always #2.5 clk = ~clk;

  task automatic model_edge(int c, int b, int cl, bit ap, bit m, int d);
    bool_step: begin
      bit mine = (b == 0);
      m_enr = 0;
      m_eap = 0;
      if (mine && c == C_ACT) begin
        m_open = 1; m_burst = 0;
      end else if (mine && c == C_WR) begin
        if (!m_open) m_enr = 1;
        else begin
          m_eap = ap;
          if (!m) mref[cl] = d;
          m_col = (cl + 1) % NC;
          m_burst = 1;
        end
      end else if (mine && c == C_BST) begin
        m_burst = 0;
      end else if (mine && c == C_PRE) begin
        m_burst = 0; m_open = 0;
      end else if (m_burst && m_open) begin
        if (!m) mref[m_col] = d;
        m_col = (m_col + 1) % NC;
      end
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (row_open !== m_open || burst_active !== m_burst || beat_col !== CW'(m_col) ||
        err_no_row !== m_enr || err_auto_pre !== m_eap) begin
      fails++;
      $display("FAIL %s: open/burst/col/enr/eap got %0b/%0b/%0d/%0b/%0b exp %0b/%0b/%0d/%0b/%0b",
               tag, row_open, burst_active, beat_col, err_no_row, err_auto_pre,
               m_open, m_burst, m_col, m_enr, m_eap);
    end
  endtask

  task automatic step(int c, int b, int cl, bit ap, bit m, int d, string tag);
    cmd = 3'(c); bank = 1'(b); col = CW'(cl); auto_pre = ap; dqm = m; din = DW'(d);
    @(posedge clk);
    model_edge(c, b, cl, ap, m, d);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic check_mem(string tag);
    for (int i = 0; i < NC; i++) begin
      peek_col = CW'(i);
      #0.1;
      checks++;
      if (peek_data !== DW'(mref[i])) begin
        fails++;
        $display("FAIL %s: array col %0d got %h exp %h", tag, i, peek_data, DW'(mref[i]));
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) mref[i] = 0;
    m_open = 0; m_burst = 0; m_col = 0; m_enr = 0; m_eap = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare("R1");
    check_mem("R1");

    // write before any activate
    step(C_WR, 0, 5, 0, 0, 'h1111, "R8");
    step(C_NOP, 0, 0, 0, 0, 'h1112, "R6");
    // activate of the other bank does nothing here
    step(C_ACT, 1, 0, 0, 0, 0, "R11");
    step(C_ACT, 0, 0, 0, 0, 0, "R3");

    // burst from column 12 across the row end
    step(C_WR, 0, 12, 0, 0, 'hA00C, "R3");
    for (int k = 1; k <= 9; k++) begin
      int cc = (12 + k) % NC;
      step((k == 3) ? 7 : C_NOP, 0, 0, 0, (k == 5), 'hA000 + cc, (k == 5) ? "R9" : "R2");
    end
    step(C_BST, 0, 0, 0, 0, 'hBEEF, "R4");
    check_mem("R2");
    step(C_NOP, 0, 0, 0, 0, 'hB0B0, "R4");
    check_mem("R4");

    // second burst: auto precharge request, foreign precharge, restart, precharge end
    step(C_WR, 0, 3, 1, 0, 'hC003, "R7");
    step(C_NOP, 0, 0, 0, 0, 'hC004, "R7");
    step(C_PRE, 1, 0, 0, 0, 'hC005, "R11");
    step(C_NOP, 0, 0, 0, 0, 'hC006, "R7");
    step(C_WR, 0, 10, 0, 0, 'hD00A, "R10");
    step(C_NOP, 0, 0, 0, 0, 'hD00B, "R10");
    step(C_PRE, 0, 0, 0, 0, 'hDEAD, "R5");
    check_mem("R5");
    step(C_NOP, 0, 0, 0, 0, 'h5555, "R6");
    step(C_NOP, 0, 0, 0, 1, 'h5556, "R6");
    step(C_WR, 0, 2, 0, 0, 'h6666, "R8");
    check_mem("R6");

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule